// File: doc/BRIEF.md
# Logic Analyzer Pattern Trigger

This block watches a 32-channel sample bus, organised as four groups of eight channels, and raises a trigger once a programmed pattern condition has been seen a set number of times. Every channel carries two qualifier bits, one demanding a high level and one demanding a low level. Four channels share each configuration byte. A single extra byte may add an edge condition on one selected channel: rising, falling or either. The edge term and all level terms are combined with AND in the same sample cycle.

Configuration is written one byte at a time through a small write port. Each sample cycle in which the combined condition holds advances an occurrence counter. When that counter reaches the programmed count, the block emits a one-cycle trigger pulse and sets a sticky triggered flag. The flag then holds until the arm input clears it together with the counter. A capture controller uses the pulse to mark the trigger point in its sample memory.

Top module: `la_pattern_trigger`

## Requirements
- R1: During and after synchronous reset, trig_pulse and triggered are 0. The configuration resets to: every level byte 0, edge byte 0, count 1, and the previous-sample register 0.
- R2: Level byte k (cfg_addr = k, 0..7) covers group k/2, where group g is sample bits 8g..8g+7. The even byte holds channels 0-3 of the group and the odd byte holds channels 4-7. For a channel at position n (0-3) inside its byte, bit 2n requires the sample bit to be 1 and bit 2n+1 requires it to be 0.
- R3: A channel with both of its qualifier bits clear places no condition on the sample. A channel with both bits set makes the condition false in every cycle.
- R4: The edge byte is at cfg_addr 8. Its bits 7:6 select the edge term: 00 none (always true), 01 rising (previous 0, current 1), 10 falling (previous 1, current 0), 11 either. The previous sample is the one seen on the prior clock.
- R5: Edge byte bits 5:0 pick the channel as group*8 + channel. A value of 32 or more never matches when an edge type is set.
- R6: A write to cfg_addr 9 only stages the count's low byte. A write to cfg_addr 10 loads the 16-bit count as {written byte, staged byte}.
- R7: A programmed count of 0 behaves as a count of 1.
- R8: Each non-arm cycle in which the condition holds and triggered is 0 increments the occurrence counter. On the clock where the counter reaches the count, trig_pulse is 1 for exactly one cycle and triggered rises together with it.
- R9: Once triggered is 1 it stays 1, and no further pulse occurs until arm.
- R10: A cycle with arm = 1 clears triggered and the occurrence counter and is not itself counted.
- R11: With no level or edge qualifier set and a count of 1, the trigger fires on the first sample cycle after arm.
- R12: Writes to cfg_addr 11-15 leave the configuration unchanged.
- R13: Configuration writes take effect from the next cycle. The cycle carrying the write is still evaluated with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| arm | input | 1 | Clears the triggered flag and occurrence counter |
| sample | input | 32 | Sample bus, one bit per channel |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered flag |

## Verification
The bench goes after channel-to-bit mapping errors: a design that swaps the even and odd bytes, or the high and low bits, fires on the wrong pattern. It also targets the count. It checks that a low-byte write alone does not change the count and that a count of zero fires on the first match; an off-by-one counter fires one match early or late. A channel with both bits set must block the trigger. Edge channel selects of 32 and above must never match, and writes to unused addresses must not disturb the settings. It checks that a trigger neither repeats nor keeps counting after it fires, and that the arm cycle itself is never counted. Randomised rounds then mix level, edge and count settings against the cycle-by-cycle model.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;

    // Channels that share one qualifier byte (two bits per channel).
    localparam int CH_PER_BYTE = 4;
    localparam int CNT_W       = 16;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_kind_e;

    typedef struct packed {
        edge_kind_e  kind;   // bits 7:6
        logic [5:0]  sel;    // bits 5:0, group*8 + channel
    } edge_cfg_t;

    // One channel against its two qualifier bits.
    function automatic logic level_ok(input logic need_hi, input logic need_lo, input logic s);
        return !(need_hi && !s) && !(need_lo && s);
    endfunction

    function automatic logic edge_hit(input edge_kind_e k, input logic cur, input logic prv);
        logic r;
        case (k)
            EDGE_RISE: r = cur && !prv;
            EDGE_FALL: r = !cur && prv;
            EDGE_ANY:  r = cur ^ prv;
            default:   r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/la_trig_cfg.sv
module la_trig_cfg
    import la_trig_pkg::*;
#(
    parameter int NLVL   = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    output logic [NLVL-1:0][7:0]       level_q,
    output edge_cfg_t                  edge_q,
    output logic [CNT_W-1:0]           count_q
);
    localparam int A_EDGE = NLVL;
    localparam int A_CLO  = NLVL + 1;
    localparam int A_CHI  = NLVL + 2;

    logic [7:0] stage_q;

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                level_q[i] <= '0;
            else if (we && addr == ADDR_W'(i))
                level_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q  <= '{kind: EDGE_NONE, sel: '0};
            stage_q <= '0;
            count_q <= CNT_W'(1);
        end else if (we) begin
            if (addr == ADDR_W'(A_EDGE))
                edge_q <= edge_cfg_t'(wdata);
            if (addr == ADDR_W'(A_CLO))
                stage_q <= wdata;
            if (addr == ADDR_W'(A_CHI))
                count_q <= {wdata, stage_q};
        end
    end

    // R12 R13: settings move only on a write strobe
    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(level_q) && $stable(edge_q) && $stable(count_q)));

    // R6: a staging write alone never changes the live count
    assert_stage_only_R6: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(A_CLO)) |=> $stable(count_q));

endmodule

// File: rtl/la_trig_level.sv
module la_trig_level
    import la_trig_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter int GROUP_W = 8
) (
    input  logic [GROUPS*GROUP_W/CH_PER_BYTE-1:0][7:0] level_q,
    input  logic [GROUPS*GROUP_W-1:0]                  sample,
    output logic                                        all_ok
);
    localparam int NCH           = GROUPS * GROUP_W;
    localparam int BYTES_PER_GRP = GROUP_W / CH_PER_BYTE;

    logic [NCH-1:0] ch_ok;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar c = 0; c < GROUP_W; c++) begin : g_ch
            localparam int RIDX = g * BYTES_PER_GRP + c / CH_PER_BYTE;
            localparam int POS  = c % CH_PER_BYTE;
            assign ch_ok[g*GROUP_W + c] = level_ok(level_q[RIDX][2*POS],
                                                   level_q[RIDX][2*POS+1],
                                                   sample[g*GROUP_W + c]);
        end
    end

    assign all_ok = &ch_ok;

endmodule

// File: rtl/la_trig_edge.sv
module la_trig_edge
    import la_trig_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  sample,
    input  edge_cfg_t       edge_cfg,
    output logic            edge_ok
);
    logic [NCH-1:0] prev_q;
    logic           in_range;
    logic           cur_bit;
    logic           prv_bit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sample;
    end

    always_comb begin
        in_range = 32'(edge_cfg.sel) < NCH;
        cur_bit  = 1'b0;
        prv_bit  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (32'(edge_cfg.sel) == i) begin
                cur_bit = sample[i];
                prv_bit = prev_q[i];
            end
        end
        if (edge_cfg.kind == EDGE_NONE)
            edge_ok = 1'b1;
        else
            edge_ok = in_range && edge_hit(edge_cfg.kind, cur_bit, prv_bit);
    end

    // R5: a select outside the bus blocks any edge term
    assert_sel_range_R5: assert property (@(posedge clk) disable iff (rst)
        (edge_cfg.kind != EDGE_NONE && 32'(edge_cfg.sel) >= NCH) |-> !edge_ok);

endmodule

// File: rtl/la_trig_count.sv
module la_trig_count
    import la_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             hit,
    input  logic [CNT_W-1:0] count_cfg,
    output logic             trig_pulse,
    output logic             triggered
);
    logic [CNT_W-1:0] occ_q;
    logic [CNT_W:0]   occ_nxt;
    logic [CNT_W:0]   target;
    logic             counting;
    logic             fire;

    always_comb begin
        target   = (count_cfg == '0) ? (CNT_W+1)'(1) : {1'b0, count_cfg};
        occ_nxt  = {1'b0, occ_q} + 1'b1;
        counting = !arm && !triggered && hit;
        fire     = counting && (occ_nxt >= target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q      <= '0;
            triggered  <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= fire;
            if (arm) begin
                occ_q     <= '0;
                triggered <= 1'b0;
            end else if (counting) begin
                occ_q <= occ_nxt[CNT_W-1:0];
                if (fire) triggered <= 1'b1;
            end
        end
    end

    // R8: the pulse never lasts two cycles
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R9: flag holds and the counter freezes until arm
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (triggered && !arm) |=> (triggered && $stable(occ_q)));

    // R10: arm clears the flag and counter
    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!triggered && !trig_pulse && occ_q == '0));

    // R8: counter idles when nothing matches
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!arm && !hit) |=> $stable(occ_q));

endmodule

// File: rtl/la_pattern_trigger.sv
module la_pattern_trigger
    import la_trig_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter int GROUP_W = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic                        arm,
    input  logic [GROUPS*GROUP_W-1:0]   sample,
    output logic                        trig_pulse,
    output logic                        triggered
);
    localparam int NCH  = GROUPS * GROUP_W;
    localparam int NLVL = NCH / CH_PER_BYTE;

    logic [NLVL-1:0][7:0] level_q;
    edge_cfg_t            edge_q;
    logic [CNT_W-1:0]     count_q;
    logic                 lvl_ok;
    logic                 edg_ok;

    la_trig_cfg #(.NLVL(NLVL), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .level_q (level_q),
        .edge_q  (edge_q),
        .count_q (count_q)
    );

    la_trig_level #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_level (
        .level_q (level_q),
        .sample  (sample),
        .all_ok  (lvl_ok)
    );

    la_trig_edge #(.NCH(NCH)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .edge_cfg (edge_q),
        .edge_ok  (edg_ok)
    );

    la_trig_count u_count (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .hit        (lvl_ok && edg_ok),
        .count_cfg  (count_q),
        .trig_pulse (trig_pulse),
        .triggered  (triggered)
    );

    // R8: the flag can only rise together with a pulse
    assert_rise_with_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(triggered) |-> trig_pulse);

    // R3: a channel with both bits set blocks the level match
    assert_both_set_R3: assert property (@(posedge clk) disable iff (rst)
        (level_q[0][0] && level_q[0][1]) |-> !lvl_ok);

endmodule

// File: tb/tb_la_pattern_trigger.sv
module tb_la_pattern_trigger;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        arm = 1'b0;
    logic [31:0] sample = '0;
    logic        trig_pulse;
    logic        triggered;

    int vectors = 0;
    int fails   = 0;
    string cur_req = "R1";

    // reference model state
    byte unsigned m_lvl[8];
    byte unsigned m_edge;
    int           m_stage;
    int           m_count;
    logic [31:0]  m_prev;
    int           m_occ;
    bit           m_trig;
    bit           m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    la_pattern_trigger dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .arm(arm), .sample(sample),
        .trig_pulse(trig_pulse), .triggered(triggered)
    );

    function automatic bit model_cond(input logic [31:0] s);
        bit ok = 1;
        int kind, sel;
        for (int ch = 0; ch < 32; ch++) begin
            int b = m_lvl[(ch / 8) * 2 + ((ch % 8) / 4)];
            int p = ch % 4;
            if (((b >> (2*p)) & 1) == 1 && s[ch] == 1'b0) ok = 0;
            if (((b >> (2*p+1)) & 1) == 1 && s[ch] == 1'b1) ok = 0;
        end
        kind = (m_edge >> 6) & 3;
        sel  = m_edge & 8'h3f;
        if (kind != 0) begin
            if (sel >= 32) ok = 0;
            else if (kind == 1 && !(s[sel] == 1'b1 && m_prev[sel] == 1'b0)) ok = 0;
            else if (kind == 2 && !(s[sel] == 1'b0 && m_prev[sel] == 1'b1)) ok = 0;
            else if (kind == 3 && s[sel] == m_prev[sel]) ok = 0;
        end
        return ok;
    endfunction

    task automatic model_clock(input bit r, input bit we, input int a, input int d,
                               input bit am, input logic [31:0] s);
        if (r) begin
            for (int i = 0; i < 8; i++) m_lvl[i] = 0;
            m_edge = 0; m_stage = 0; m_count = 1; m_prev = '0;
            m_occ = 0; m_trig = 0; m_pulse = 0;
            return;
        end
        m_pulse = 0;
        if (am) begin
            m_occ = 0; m_trig = 0;
        end else if (!m_trig && model_cond(s)) begin
            m_occ = m_occ + 1;
            if (m_occ >= ((m_count == 0) ? 1 : m_count)) begin
                m_trig = 1; m_pulse = 1;
            end
        end
        if (we) begin
            if (a < 8) m_lvl[a] = byte'(d);
            else if (a == 8) m_edge = byte'(d);
            else if (a == 9) m_stage = d;
            else if (a == 10) m_count = (d << 8) | m_stage;
        end
        m_prev = s;
    endtask

    task automatic step(input bit r, input bit we, input int a, input int d,
                        input bit am, input logic [31:0] s);
        rst = r; cfg_we = we; cfg_addr = 4'(a); cfg_wdata = 8'(d); arm = am; sample = s;
        @(posedge clk);
        model_clock(r, we, a, d, am, s);
        @(negedge clk);
        vectors++;
        if (trig_pulse !== m_pulse || triggered !== m_trig) begin
            fails++;
            $display("FAIL %s t=%0t pulse/flag actual=%b%b expected=%b%b",
                     cur_req, $time, trig_pulse, triggered, m_pulse, m_trig);
        end
    endtask

    task automatic wr(input int a, input int d, input logic [31:0] s);
        step(0, 1, a, d, 0, s);
    endtask
    task automatic run(input logic [31:0] s);
        step(0, 0, 0, 0, 0, s);
    endtask
    task automatic do_arm(input logic [31:0] s);
        step(0, 0, 0, 0, 1, s);
    endtask
    task automatic clear_cfg();
        for (int i = 0; i < 9; i++) wr(i, 0, '0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low; defaults give no qualifiers, count 1
        cur_req = "R1";
        step(1, 0, 0, 0, 0, 32'hFFFF_FFFF);
        step(1, 0, 0, 0, 0, 32'h0);
        // R11: first sample after reset/arm fires with no qualifiers
        cur_req = "R11";
        run(32'h1234_5678);
        // R9: sticky, no repeat pulse
        cur_req = "R9";
        run(32'h0); run(32'hFFFF_FFFF); run(32'h0);
        cur_req = "R11";
        do_arm(32'h0);
        run(32'h0);
        run(32'h0);

        // R2 R6 R13: group A channel 0 must be high, count 3 staged then committed
        cur_req = "R6";
        wr(0, 8'h01, 32'h0);
        wr(9, 8'h03, 32'h1);
        do_arm(32'h0);
        run(32'h1); run(32'h1);           // count still 1: fires on first match
        do_arm(32'h0);
        wr(10, 8'h00, 32'h1);             // commit cycle counts with old count? triggered path
        do_arm(32'h0);
        cur_req = "R8";
        run(32'h1); run(32'h0); run(32'h1); run(32'h0); run(32'h1); run(32'h1); run(32'h1);

        // R2: group D channel 6 must be low (byte 7, bit 5)
        cur_req = "R2";
        wr(0, 0, 32'h0);
        wr(9, 1, 32'h0); wr(10, 0, 32'h0);
        wr(7, 8'h20, 32'h0);
        do_arm(32'hFFFF_FFFF);
        run(32'hFFFF_FFFF); run(32'h4000_0000); run(32'hBFFF_FFFF);
        // group B channel 2 high (byte 2, bit 4)
        wr(7, 0, 32'h0); wr(2, 8'h10, 32'h0);
        do_arm(32'h0);
        run(32'h0000_0400); run(32'h0);   // channel 10 is bit 10
        do_arm(32'h0);
        run(32'h0); run(32'h0000_0400);

        // R3: both bits set on group C channel 6 (byte 5, bits 5:4)
        cur_req = "R3";
        wr(2, 0, 32'h0); wr(5, 8'h30, 32'h0);
        do_arm(32'h0);
        for (int i = 0; i < 8; i++) run((i % 2) ? 32'h0040_0000 : 32'h0);
        wr(5, 0, 32'h0); wr(0, 8'h03, 32'h0);
        do_arm(32'h0);
        run(32'h1); run(32'h0);
        wr(0, 0, 32'h0);
        do_arm(32'h0);

        // R4 R5: rising on group B channel 3 (select 11), count 2
        cur_req = "R4";
        wr(9, 2, 32'h0); wr(10, 0, 32'h0);
        wr(8, 8'h40 | 11, 32'h0);
        do_arm(32'h0);
        run(32'h800); run(32'h800); run(32'h0); run(32'h800); run(32'h0);
        cur_req = "R5";
        wr(8, 8'h80 | 29, 32'h2000_0000);
        do_arm(32'h2000_0000);
        run(32'h0); run(32'h2000_0000); run(32'h0); run(32'h0);
        cur_req = "R4";
        wr(8, 8'hC0 | 7, 32'h0);
        do_arm(32'h0);
        run(32'h80); run(32'h0); run(32'h0);
        cur_req = "R5";
        wr(8, 8'h40 | 8'h25, 32'h0);
        do_arm(32'h0);
        for (int i = 0; i < 6; i++) run((i % 2) ? 32'hFFFF_FFFF : 32'h0);

        // R7: count of zero acts as one
        cur_req = "R7";
        wr(8, 0, 32'h0); wr(9, 0, 32'h0); wr(10, 0, 32'h0);
        do_arm(32'h0);
        run(32'h0); run(32'h0);

        // R12: unused addresses ignored
        cur_req = "R12";
        wr(0, 8'h01, 32'h0);
        for (int a = 11; a < 16; a++) wr(a, 8'hFF, 32'h0);
        do_arm(32'h0);
        run(32'h0); run(32'h0); run(32'h1);
        wr(0, 0, 32'h0);

        // R2 R4 R5 R8 R10: randomised rounds
        cur_req = "R8";
        for (int round = 0; round < 30; round++) begin
            int nq = $urandom_range(0, 2);
            clear_cfg();
            for (int q = 0; q < nq; q++)
                wr($urandom_range(0, 7), 1 << $urandom_range(0, 7), 32'($urandom));
            if ($urandom_range(0, 1) == 1)
                wr(8, ($urandom_range(0, 3) << 6) | $urandom_range(0, 33), 32'($urandom));
            wr(9, $urandom_range(0, 3), 32'($urandom));
            wr(10, 0, 32'($urandom));
            do_arm(32'($urandom));
            for (int c = 0; c < 20; c++) begin
                if (c == 12 && $urandom_range(0, 1) == 1) do_arm(32'($urandom));
                else run(32'($urandom));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule